// File: doc/BRIEF.md
# Reference-Gated Cycle Counter

This block measures a fast, loosely trimmed oscillator against a slow, accurate reference clock. After a start request it waits until the reference clock has produced a chosen number N of rising edges, and only then opens a counting window. The window stays open for a further N reference periods. The result is the number of fast-clock cycles that fall inside that window, so it is roughly N times the ratio of the fast frequency to the reference frequency. A trimming loop outside the block uses this raw count to steer the oscillator.

All ports except the reference clock belong to the fast clock domain. The reference clock passes through a flop synchronizer, and its rising edges become one-cycle strobes. The first window of N strobes lines up the count with a reference edge before any fast cycle is counted. The fast counter saturates at all ones and flags the overflow, so a badly chosen N can never wrap the result.

Top module: `ref_gated_counter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, busy_o, done_o, ovf_o and count_o are all zero.
- R2: A start_i sampled high while busy_o is low sets busy_o from the next cycle, and the block latches meas_n_i at that edge.
- R3: Counting of fast cycles begins only at the N-th synchronized reference rising edge after start. A whole alignment window of N reference periods always comes before the counted window.
- R4: The result equals the number of fast-clock edges from the N-th synchronized reference rising edge after start up to and including the 2N-th one. A reference rising edge takes effect on the third fast-clock edge that samples it high.
- R5: For a steady clock ratio, count_o lies within 2 of N·Tref/Tfast.
- R6: done_o is high for exactly one cycle, on the same cycle that busy_o drops. count_o and ovf_o update only at that point and hold their value until the next done_o.
- R7: A start_i received while busy_o is high is ignored. The running measurement keeps its original N, and the one result it produces corresponds to that N.
- R8: meas_n_i equal to 0 is treated as N = 1.
- R9: When the true count reaches or exceeds 2^CNT_W−1, count_o is all ones and ovf_o is 1. Otherwise ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock being measured |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Slow precise reference clock, asynchronous |
| start_i | input | 1 | Start request, sampled while idle |
| meas_n_i | input | CNT_W | Window length in reference periods (0 counts as 1) |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| count_o | output | CNT_W | Fast cycles counted in the window, saturating |
| ovf_o | output | 1 | Count reached all ones |

## Verification
The bench builds the block with CNT_W = 10 and two synchronizer stages. With a 10-bit counter, saturation and the overflow flag can be reached after about a thousand fast cycles, where 16 bits would need tens of thousands. The reference clock is given unequal high and low phases, which produces half-integer period ratios, and its edges never coincide with a fast rising edge, so the bench model knows the exact sampling cycle. A behavioural model tracks every cycle. Separate checks cover the ±2 accuracy bound, the alignment delay, N = 0, and a start issued mid-measurement.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } meas_state_e;
endpackage

// File: rtl/rgc_edge_sync.sv
module rgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rgc_sat_counter.sv
module rgc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_next_o,
  output logic         ovf_next_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_comb begin
    cnt_next_o = (cnt_q == MaxVal) ? MaxVal : cnt_q + 1'b1;
    ovf_next_o = ovf_q | (cnt_next_o == MaxVal);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en_i) begin
      cnt_q <= cnt_next_o;
      ovf_q <= ovf_next_o;
    end
  end
endmodule

// File: rtl/rgc_ctrl.sv
module rgc_ctrl
  import rgc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] n_i,
  input  logic         rise_i,
  input  logic [W-1:0] fast_next_i,
  input  logic         fast_ovf_i,
  output logic         cnt_clr_o,
  output logic         cnt_en_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  meas_state_e  state_q;
  logic [W-1:0] n_eff_q;
  logic [W-1:0] ref_cnt_q;
  logic         last_edge;

  assign last_edge = rise_i && (ref_cnt_q == n_eff_q - 1'b1);
  assign cnt_clr_o = (state_q == ST_ARM) && last_edge;
  assign cnt_en_o  = (state_q == ST_COUNT);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      n_eff_q   <= '0;
      ref_cnt_q <= '0;
      done_o    <= 1'b0;
      count_o   <= '0;
      ovf_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            n_eff_q   <= (n_i == '0) ? W'(1) : n_i;
            ref_cnt_q <= '0;
            state_q   <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (last_edge) begin
            ref_cnt_q <= '0;
            state_q   <= ST_COUNT;
          end else if (rise_i) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
          end
        end
        ST_COUNT: begin
          if (last_edge) begin
            count_o <= fast_next_i;
            ovf_o   <= fast_ovf_i;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rise_i) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ref_gated_counter.sv
module ref_gated_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] meas_n_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic             ref_rise;
  logic             cnt_clr, cnt_en, fast_ovf;
  logic [CNT_W-1:0] fast_next;

  rgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ref_clk_i),
    .rise_o  (ref_rise)
  );

  rgc_sat_counter #(.W(CNT_W)) u_fast (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_clr),
    .en_i       (cnt_en),
    .cnt_next_o (fast_next),
    .ovf_next_o (fast_ovf)
  );

  rgc_ctrl #(.W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .n_i         (meas_n_i),
    .rise_i      (ref_rise),
    .fast_next_i (fast_next),
    .fast_ovf_i  (fast_ovf),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .count_o     (count_o),
    .ovf_o       (ovf_o)
  );
endmodule

// File: rtl/rgc_checker.sv
module rgc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(count_o) && $stable(ovf_o)); // R6
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R2
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> busy_o || done_o); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == {CNT_W{1'b1}}); // R9
endmodule

bind ref_gated_counter rgc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .count_o (count_o),
  .ovf_o   (ovf_o)
);

// File: tb/ref_gated_counter_tb.sv
`timescale 1ns/1ps
module ref_gated_counter_tb;
  localparam int CNT_W = 10;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_clk = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] meas_n = '0;
  logic             busy, done, ovf;
  logic [CNT_W-1:0] count;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int hi_u = 5, lo_u = 5;  // reference phases in units of 4 ns

  ref_gated_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .start_i(start),
    .meas_n_i(meas_n), .busy_o(busy), .done_o(done), .count_o(count), .ovf_o(ovf)
  );

  always #4 clk = ~clk;  // 125 MHz, rising edges at 4 mod 8 ns

  // reference edges land on 2 or 6 mod 8 ns, never on a fast rising edge
  initial begin
    #2;
    forever begin
      ref_clk = 1'b1; #(4 * hi_u);
      ref_clk = 1'b0; #(4 * lo_u);
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference model
  bit m_s1, m_s2, m_s3, m_done, m_ovf;
  int m_state, m_rc, m_n, m_fast, m_count;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_done = 0; m_ovf = 0;
      m_state = 0; m_rc = 0; m_n = 0; m_fast = 0; m_count = 0;
    end else begin
      bit rise;
      rise = m_s2 && !m_s3;
      m_done = 0;
      if (m_state == 0) begin
        if (start) begin m_n = (meas_n == 0) ? 1 : int'(meas_n); m_rc = 0; m_state = 1; end
      end else if (m_state == 1) begin
        if (rise) begin
          m_rc++;
          if (m_rc == m_n) begin m_rc = 0; m_fast = 0; m_state = 2; end
        end
      end else begin
        m_fast++;
        if (rise) begin
          m_rc++;
          if (m_rc == m_n) begin
            m_count = (m_fast >= MAXV) ? MAXV : m_fast;
            m_ovf = (m_fast >= MAXV);
            m_done = 1; m_state = 0;
          end
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc > 1) begin
      check(busy == (m_state != 0), "R2 busy", int'(busy), int'(m_state != 0));
      check(done == m_done, "R6 done", int'(done), int'(m_done));
      check(int'(count) == m_count, "R4 count", int'(count), m_count);
      check(ovf == m_ovf, "R9 ovf", int'(ovf), int'(m_ovf));
    end
  end

  // one measurement; optional extra start mid-run with another N
  task automatic measure(input int n, input int h, input int l, input int late_n,
                         input string tag);
    int t0, elapsed, n_eff;
    real ratio, expv;
    hi_u = h; lo_u = l;
    repeat (8 * (h + l)) @(negedge clk);
    n_eff = (n == 0) ? 1 : n;
    ratio = real'(h + l) / 2.0;
    meas_n = CNT_W'(n); start = 1'b1;
    @(negedge clk); start = 1'b0; t0 = cyc;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (late_n >= 0) begin
      repeat (10) @(negedge clk);
      meas_n = CNT_W'(late_n); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R7 still busy", int'(busy), 1);
    end
    while (!done && cyc - t0 < 20000) @(negedge clk);
    elapsed = cyc - t0;
    expv = ratio * n_eff;
    if (expv < MAXV - 3) begin
      check((real'(count) >= expv - 2.0) && (real'(count) <= expv + 2.0),
            {tag, " R5 ratio"}, int'(count), int'(expv));
      check(ovf == 1'b0, {tag, " R9 no ovf"}, int'(ovf), 0);
    end else begin
      check(count == CNT_W'(MAXV) && ovf, {tag, " R9 saturate"}, int'(count), MAXV);
    end
    // R3: alignment window of N periods precedes the counted window
    check(real'(elapsed - int'(count)) >= ratio * (n_eff - 1) - 1.0,
          {tag, " R3 alignment"}, elapsed - int'(count), int'(ratio * (n_eff - 1)));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {tag, " R6 single pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !ovf && count == '0, "R1 in reset", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !ovf && count == '0, "R1 after reset", int'(count), 0);
    measure(8, 5, 5, -1, "ratio5");
    measure(20, 2, 3, -1, "ratio2.5");
    measure(3, 7, 6, -1, "ratio6.5");
    measure(0, 7, 6, -1, "R8 n0");
    measure(4, 5, 5, 50, "R7 late start");
    repeat (200) @(negedge clk);
    check(!busy, "R7 no second run", int'(busy), 0);
    measure(300, 5, 5, -1, "overflow");
    measure(2, 5, 5, -1, "after ovf");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule